// File: doc/BRIEF.md
# Adaptive Slope-Compensated Current Reference Generator

This block builds the analog current reference for a cycle-by-cycle current-limited inverter. At every switching-period strobe it takes a new sinusoidal reference sample. On every later clock tick of that period it subtracts a linear compensation ramp from the sample. A fixed offset is added to the result, which is then clamped to the 12-bit code range of an external DAC. The sensed current signal carries the same offset ahead of the comparator, so the two signals compare on equal terms.

The ramp slope is chosen again at each strobe. In constant mode it is a programmed value. In adaptive mode it is proportional to the magnitude of the sampled output voltage, multiplied by a programmable gain, shifted right, and capped at a programmable maximum. With the gain set so that the slope is at least half the inductor-current down-slope, compensation fades near the output-voltage zero crossing. There the down-slope is small, so a ramp that matches it cannot hold the trip low over many periods.

Top module: `slope_ref_gen`

## Requirements
- R1: After reset the DAC code equals the offset OFFSET (default 2400), because the stored reference sample and the ramp both reset to zero.
- R2: On the clock edge where period_start is 1, the block latches ref_in (two's complement) and restarts the ramp at zero. From the next cycle the code is OFFSET + ref_in, clamped.
- R3: The ramp has FRAC_W (default 8) fraction bits. After each clock edge with period_start at 0, the slope is added to it, and the code is OFFSET + ref - floor(ramp / 2^FRAC_W), clamped. The code never rises within a period.
- R4: The slope, mode and reference are sampled only at period_start. Changes to ref_in, const_slope, adapt_en, vout_in, gain or slope_max in the middle of a period do not change the codes of that period.
- R5: With adapt_en at 0, the slope latched at a strobe is const_slope.
- R6: With adapt_en at 1, the slope latched at a strobe is min((|vout_in| * gain) >> GAIN_SHIFT, slope_max), with GAIN_SHIFT defaulting to 4 and vout_in in two's complement.
- R7: In adaptive mode a zero output-voltage sample gives a zero slope, so the code stays flat at OFFSET + ref for the whole period.
- R8: The code saturates at 0 when the difference is negative and at 4095 when it exceeds 4095.
- R9: The ramp accumulator (CODE_W+FRAC_W+1 bits) saturates at its all-ones value instead of wrapping, so a long period with a steep slope keeps the code at its low clamp.
- R10: When period_start is 1 on consecutive edges, each edge restarts the ramp. The restart takes precedence over the ramp step, so the code stays at OFFSET + ref.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_start | input | 1 | One-cycle strobe at the start of each switching period |
| adapt_en | input | 1 | 1 selects the adaptive slope, 0 selects the constant slope |
| ref_in | input | CODE_W | Sinusoidal reference sample, two's complement |
| vout_in | input | VOUT_W | Output-voltage sample, two's complement |
| const_slope | input | SLOPE_W | Constant slope per tick, with FRAC_W fraction bits |
| gain | input | GAIN_W | Adaptive gain multiplier |
| slope_max | input | SLOPE_W | Upper limit on the adaptive slope |
| dac_code | output | CODE_W | Compensated reference code for the DAC |

## Verification
A period strobe and a ramp step can fall on the same edge, and the restart must win. This is provoked by asserting the strobe on consecutive cycles with a steep slope and a mid-range reference. The result is judged correct only if the code stays at offset plus reference on every one of those cycles. Saturation of the accumulator can also meet a restart after a long steep period. That case is checked by having the first code after the strobe return exactly to the new reference level.

// File: rtl/slope_ref_gen.sv
module slope_ref_gen #(
  parameter int CODE_W     = 12,
  parameter int VOUT_W     = 12,
  parameter int FRAC_W     = 8,
  parameter int SLOPE_W    = 16,
  parameter int GAIN_W     = 8,
  parameter int GAIN_SHIFT = 4,
  parameter int OFFSET     = 2400
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     period_start,
  input  logic                     adapt_en,
  input  logic signed [CODE_W-1:0] ref_in,
  input  logic signed [VOUT_W-1:0] vout_in,
  input  logic [SLOPE_W-1:0]       const_slope,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [SLOPE_W-1:0]       slope_max,
  output logic [CODE_W-1:0]        dac_code
);
  localparam int RAMP_W = CODE_W + FRAC_W + 1;
  localparam int PROD_W = VOUT_W + GAIN_W;
  localparam int CMP_W  = (PROD_W > SLOPE_W) ? PROD_W : SLOPE_W;
  localparam int SUM_W  = RAMP_W + 2;
  localparam logic signed [SUM_W-1:0] CODE_TOP = SUM_W'((1 << CODE_W) - 1);

  logic [CODE_W-1:0]  ref_q;
  logic [SLOPE_W-1:0] slope_q;
  logic [RAMP_W-1:0]  ramp_acc;

  logic [VOUT_W-1:0]  vout_mag;
  logic [PROD_W-1:0]  prod;
  logic [CMP_W-1:0]   scaled, cap;
  logic [SLOPE_W-1:0] adapt_slope, next_slope;
  logic [RAMP_W:0]    ramp_sum;
  logic [RAMP_W-1:0]  ramp_next;
  logic signed [SUM_W-1:0] diff;

  assign vout_mag    = vout_in[VOUT_W-1] ? VOUT_W'(-vout_in) : VOUT_W'(vout_in);
  assign prod        = PROD_W'(vout_mag) * PROD_W'(gain);
  assign scaled      = CMP_W'(prod >> GAIN_SHIFT);
  assign cap         = CMP_W'(slope_max);
  assign adapt_slope = (scaled > cap) ? slope_max : SLOPE_W'(scaled);
  assign next_slope  = adapt_en ? adapt_slope : const_slope;

  assign ramp_sum  = {1'b0, ramp_acc} + (RAMP_W+1)'(slope_q);
  assign ramp_next = ramp_sum[RAMP_W] ? {RAMP_W{1'b1}} : ramp_sum[RAMP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q    <= '0;
      slope_q  <= '0;
      ramp_acc <= '0;
    end else if (period_start) begin
      ref_q    <= ref_in;
      slope_q  <= next_slope;
      ramp_acc <= '0;
    end else begin
      ramp_acc <= ramp_next;
    end
  end

  assign diff = SUM_W'(OFFSET)
              + {{(SUM_W-CODE_W){ref_q[CODE_W-1]}}, ref_q}
              - SUM_W'(ramp_acc >> FRAC_W);

  assign dac_code = (diff < 0) ? '0 : (diff > CODE_TOP) ? CODE_TOP[CODE_W-1:0] : CODE_W'(diff);

  p_code_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> dac_code <= $past(dac_code));

  p_slope_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(slope_q));

  p_slope_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && adapt_en) |=> slope_q <= $past(slope_max));

  p_zero_flat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && adapt_en && vout_in == '0) |=> slope_q == '0);

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> ramp_acc >= $past(ramp_acc));
endmodule

// File: tb/sim_slope_ref_gen.sv
module sim_slope_ref_gen;
  localparam int RMAX = (1 << 21) - 1;

  logic clk = 0, rst_n = 0, period_start = 0, adapt_en = 0;
  logic signed [11:0] ref_in = 0, vout_in = 0;
  logic [15:0] const_slope = 0, slope_max = 16'hFFFF;
  logic [7:0] gain = 0;
  logic [11:0] dac_code;

  int checks = 0, errors = 0;
  int m_ref = 0, m_slope = 0, m_ramp = 0;

  always #10 clk = ~clk;

  slope_ref_gen u0 (.clk(clk), .rst_n(rst_n), .period_start(period_start), .adapt_en(adapt_en),
    .ref_in(ref_in), .vout_in(vout_in), .const_slope(const_slope), .gain(gain),
    .slope_max(slope_max), .dac_code(dac_code));

  function automatic int f_slope();
    int mag, s;
    if (!adapt_en) return int'(const_slope);
    mag = (vout_in < 0) ? -int'(vout_in) : int'(vout_in);
    s = (mag * int'(gain)) >>> 4;
    if (s > int'(slope_max)) s = int'(slope_max);
    return s;
  endfunction

  function automatic int f_code();
    int d;
    d = 2400 + m_ref - (m_ramp >>> 8);
    if (d < 0) d = 0;
    if (d > 4095) d = 4095;
    return d;
  endfunction

  task automatic check(input string tag, input int exp);
    checks++;
    if (int'(dac_code) != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, dac_code, exp);
    end
  endtask

  task automatic step(input bit strb, input string tag);
    period_start = strb;
    if (strb) begin
      m_ref = int'(ref_in); m_slope = f_slope(); m_ramp = 0;
    end else begin
      m_ramp = m_ramp + m_slope;
      if (m_ramp > RMAX) m_ramp = RMAX;
    end
    @(posedge clk); @(negedge clk);
    period_start = 0;
    check(tag, f_code());
  endtask

  task automatic t_reset();
    check("R1 reset code", 2400);
  endtask

  task automatic t_const();
    adapt_en = 0; const_slope = 16'h0180; ref_in = 300;
    step(1, "R2 latch");
    for (int i = 0; i < 12; i++) step(0, "R3 R5 const ramp");
  endtask

  task automatic t_hold();
    adapt_en = 0; const_slope = 16'h0200; ref_in = -500;
    step(1, "R2 latch neg");
    for (int i = 0; i < 3; i++) step(0, "R3 ramp");
    const_slope = 16'h4000; adapt_en = 1; vout_in = 2000; gain = 255; ref_in = -1000; slope_max = 16'hFFFF;
    for (int i = 0; i < 5; i++) step(0, "R4 mid-period change ignored");
  endtask

  task automatic t_adapt();
    adapt_en = 1; vout_in = -800; gain = 20; slope_max = 16'hFFFF; ref_in = 900;
    step(1, "R6 adaptive latch");
    for (int i = 0; i < 8; i++) step(0, "R6 adaptive ramp");
    vout_in = 1000; gain = 255; slope_max = 600; ref_in = 100;
    step(1, "R6 capped latch");
    for (int i = 0; i < 8; i++) step(0, "R6 capped ramp");
  endtask

  task automatic t_zero();
    adapt_en = 1; vout_in = 0; gain = 200; ref_in = 50; const_slope = 16'h8000;
    step(1, "R7 zero latch");
    for (int i = 0; i < 20; i++) step(0, "R7 flat");
  endtask

  task automatic t_clamp();
    adapt_en = 0; const_slope = 16'h0100; ref_in = 2047;
    step(1, "R8 high clamp");
    for (int i = 0; i < 4; i++) step(0, "R8 high clamp");
    const_slope = 16'h4000; ref_in = -2048;
    step(1, "R8 low start");
    for (int i = 0; i < 10; i++) step(0, "R8 low clamp");
  endtask

  task automatic t_long();
    adapt_en = 0; const_slope = 16'hFFFF; ref_in = 2047;
    step(1, "R9 start");
    for (int i = 0; i < 100; i++) step(0, "R9 saturate");
    ref_in = 10;
    step(1, "R9 restart after saturation");
  endtask

  task automatic t_b2b();
    adapt_en = 0; const_slope = 16'h2000; ref_in = 700;
    for (int i = 0; i < 6; i++) step(1, "R10 back-to-back");
    step(0, "R10 then ramp");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset(); t_const(); t_hold(); t_adapt(); t_zero(); t_clamp(); t_long(); t_b2b();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule